// File: doc/BRIEF.md
# Asynchronous Character Transmitter with Line Control

This block sends characters on an asynchronous serial line. A host writes a character into a one-entry holding register. At the next frame boundary the character moves into a shift register and goes out as one frame: a start bit, then 7 or 8 data bits least-significant first, then an optional parity bit, then one or two stop bits. A three-bit format code picks the frame shape. An external bit-rate enable marks each bit period, so the block sends one bit per enable pulse.

A two-bit control field sets three things with one code: the request-to-send level, whether the transmit interrupt is allowed, and whether the line is held in a continuous break. The block reports when the holding register is free and when the whole transmitter is idle. A host can use either flag to pace its writes.

Top module: `uart_char_tx`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1, `tx_idle` is 1, and with `tx_ctl`=00 both `rts_out` and `tx_irq` are 0.
- R2: A frame begins with a low start bit. The data bits follow least-significant first. Each bit lasts exactly one `bit_en` period, and the line sits high (marking) between frames.
- R3: The format code `fmt` gives the frame shape as data bits / parity / stop bits:
  - 000 = 7 / even / 2
  - 001 = 7 / odd / 2
  - 010 = 7 / even / 1
  - 011 = 7 / odd / 1
  - 100 = 8 / none / 2
  - 101 = 8 / none / 1
  - 110 = 8 / even / 1
  - 111 = 8 / odd / 1
- R4: When parity is on, the parity bit comes straight after the last data bit and before the first stop bit. With even parity the data bits plus the parity bit hold an even number of ones. With odd parity they hold an odd number.
- R5: `hold_empty` goes to 0 in the cycle after a write (`wr_en`). It returns to 1 at the `bit_en` pulse that moves the character into the shift register, which is the pulse where the start bit appears.
- R6: `tx_idle` is 1 only when the holding register and the shift register are both empty. Either one holding a character makes it 0. It returns to 1 at the pulse that follows the last stop bit.
- R7: A character written while a frame is in progress starts at the `bit_en` pulse that ends that frame, with no idle bit in between.
- R8: `rts_out` is 1 only for `tx_ctl`=10. `tx_irq` is 1 only when `tx_ctl`=01 and `hold_empty` is 1.
- R9: With `tx_ctl`=11, `txd` is held at 0 from the next frame boundary. A frame already in progress completes first. A waiting character is not sent while the break is held. After the code leaves 11, the next `bit_en` pulse either returns the line to 1 or starts the waiting character.
- R10: In the 7-bit formats, bit 7 of the written data is not sent and has no effect on parity.
- R11: `txd` changes only in the cycle after a `bit_en` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One-cycle pulse per bit period |
| fmt | input | 3 | Frame format code (R3) |
| tx_ctl | input | 2 | RTS / interrupt / break control code |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line, 1 = marking |
| rts_out | output | 1 | Request-to-send level |
| tx_irq | output | 1 | Transmit interrupt request |
| hold_empty | output | 1 | Holding register is free |
| tx_idle | output | 1 | Holding and shift registers both empty |

## Verification
A wrong bit counter shows up on `txd` within a single frame. The last bit is either cut short or stretched, so the stop level or the next start bit appears one `bit_en` period early or late. A holding flag left set or cleared by mistake shows up at the very next load pulse: `hold_empty` and `tx_idle` then disagree with the write history. The sweep runs every format code against data patterns with differing ones counts, so a misplaced or inverted parity bit is caught within the frame where it occurs. A break that is applied too early shows up as a truncated frame. A break that is released too late shows up as a missing start bit after the code changes.

// File: rtl/uart_char_tx.sv
module uart_char_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic [2:0] fmt,
  input  logic [1:0] tx_ctl,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       rts_out,
  output logic       tx_irq,
  output logic       hold_empty,
  output logic       tx_idle
);
  localparam int FW = 12;
  localparam int CW = 4;

  logic [7:0]    hold_q;
  logic          hold_full;
  logic [FW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          busy;
  logic          brk_line;

  logic          wide, par_on, two_stop, par_bit, brk_req, boundary, load;
  logic [FW-1:0] frame;
  logic [CW-1:0] flen;

  assign wide     = fmt[2];
  assign par_on   = (fmt[2:1] != 2'b10);
  assign two_stop = wide ? (fmt[1:0] == 2'b00) : ~fmt[1];
  assign par_bit  = (^(wide ? hold_q : {1'b0, hold_q[6:0]})) ^ fmt[0];
  assign flen     = CW'(9) + CW'(wide) + CW'(par_on) + CW'(two_stop);

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < 7 || wide) frame[i+1] = hold_q[i];
    if (par_on) frame[wide ? 9 : 8] = par_bit;
  end

  assign brk_req  = (tx_ctl == 2'b11);
  assign boundary = bit_en && (!busy || cnt_q == CW'(1));
  assign load     = boundary && hold_full && !brk_req;

  assign rts_out    = (tx_ctl == 2'b10);
  assign hold_empty = !hold_full;
  assign tx_irq     = (tx_ctl == 2'b01) && hold_empty;
  assign tx_idle    = hold_empty && !busy;
  assign txd        = busy ? sh_q[0] : !brk_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (wr_en) begin
      hold_q    <= wr_data;
      hold_full <= 1'b1;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '1;
      cnt_q    <= '0;
      busy     <= 1'b0;
      brk_line <= 1'b0;
    end else if (boundary) begin
      busy     <= load;
      brk_line <= brk_req;
      if (load) begin
        sh_q  <= frame;
        cnt_q <= flen;
      end
    end else if (bit_en) begin
      sh_q  <= {1'b1, sh_q[FW-1:1]};
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // R11
  line_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(bit_en));
  // R5
  fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_empty) |-> $past(wr_en));
  // R5
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty) |-> $past(bit_en));
  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  // R6
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> hold_empty);
endmodule

// File: tb/uart_char_tx_bench.sv
module uart_char_tx_bench;
  logic clk = 0, rst_n = 0, bit_en = 0, wr_en = 0;
  logic [2:0] fmt = 0;
  logic [1:0] tx_ctl = 0;
  logic [7:0] wr_data = 0;
  logic txd, rts_out, tx_irq, hold_empty, tx_idle;
  int total = 0, fails = 0;

  always #5 clk = ~clk;

  uart_char_tx u_uart_char_tx (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fmt(fmt),
    .tx_ctl(tx_ctl), .wr_en(wr_en), .wr_data(wr_data), .txd(txd), .rts_out(rts_out),
    .tx_irq(tx_irq), .hold_empty(hold_empty), .tx_idle(tx_idle));

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) bit_en = 1;
    @(negedge clk) bit_en = 0;
    @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk) begin wr_en = 1; wr_data = d; end
    @(negedge clk) wr_en = 0;
  endtask

  function automatic int nbits(input logic [2:0] f); return f[2] ? 8 : 7; endfunction
  function automatic int pkind(input logic [2:0] f);
    case (f) 3'd4, 3'd5: return 0; default: return f[0] ? 2 : 1; endcase
  endfunction
  function automatic int nstop(input logic [2:0] f);
    case (f) 3'd0, 3'd1, 3'd4: return 2; default: return 1; endcase
  endfunction
  function automatic int flen(input logic [2:0] f);
    return 1 + nbits(f) + (pkind(f) != 0) + nstop(f);
  endfunction
  function automatic int ebit(input logic [2:0] f, input logic [7:0] d, input int i);
    int n = nbits(f);
    int ones = 0;
    for (int k = 0; k < n; k++) ones += d[k];
    if (i == 0) return 0;
    if (i <= n) return d[i-1];
    if (i == n + 1 && pkind(f) != 0) return (ones % 2) ^ (pkind(f) == 2);
    return 1;
  endfunction

  task automatic send_frame(input logic [2:0] f, input logic [7:0] d);
    string lbl;
    fmt = f;
    put(d);
    chk("R5 full after write", hold_empty, 0);
    chk("R6 busy after write", tx_idle, 0);
    tick();
    chk("R2 start bit", txd, 0);
    chk("R5 empty at load", hold_empty, 1);
    for (int i = 1; i < flen(f); i++) begin
      tick();
      if (!f[2] && d[7]) lbl = "R10 frame bit";
      else if (i <= nbits(f)) lbl = "R2 data bit";
      else if (i == nbits(f) + 1 && pkind(f) != 0) lbl = "R4 parity bit";
      else lbl = "R3 stop bit";
      chk(lbl, txd, ebit(f, d, i));
    end
    tick();
    chk("R3 frame length line high", txd, 1);
    chk("R6 idle after frame", tx_idle, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] pats [8] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h01, 8'h7F, 8'h3C};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 txd", txd, 1);
    chk("R1 hold_empty", hold_empty, 1);
    chk("R1 tx_idle", tx_idle, 1);
    chk("R1 rts", rts_out, 0);
    chk("R1 irq", tx_irq, 0);

    for (int f = 0; f < 8; f++)
      for (int p = 0; p < 8; p++) send_frame(3'(f), pats[p]);

    // R8: every control code with the holding register empty and full
    for (int c = 0; c < 4; c++) begin
      tx_ctl = 2'(c);
      @(negedge clk);
      chk("R8 rts empty", rts_out, c == 2);
      chk("R8 irq empty", tx_irq, c == 1);
      put(8'h11);
      chk("R8 rts full", rts_out, c == 2);
      chk("R8 irq full", tx_irq, 0);
      tx_ctl = 0;
      fmt = 3'd5;
      tick();
      repeat (10) tick();
      chk("R8 drained", tx_idle, 1);
    end

    // R11: the line holds between pulses
    fmt = 3'd5;
    put(8'h00);
    tick();
    repeat (4) @(negedge clk);
    chk("R11 start holds without tick", txd, 0);
    repeat (9) tick();
    chk("R11 last stop", txd, 1);
    tick();

    // R7: back-to-back frames
    fmt = 3'd5;
    put(8'hFF);
    tick();
    put(8'h00);
    chk("R7 second waiting", hold_empty, 0);
    for (int i = 1; i < 10; i++) begin tick(); chk("R7 first frame bit", txd, 1); end
    tick();
    chk("R7 second start without gap", txd, 0);
    chk("R7 hold freed", hold_empty, 1);
    for (int i = 1; i < 10; i++) begin tick(); chk("R7 second frame bit", txd, ebit(3'd5, 8'h00, i)); end
    tick();
    chk("R7 idle", tx_idle, 1);

    // R9: break requested mid-frame, char waiting, then release
    fmt = 3'd5;
    put(8'hFF);
    tick();
    tick(); tick();
    tx_ctl = 2'b11;
    for (int i = 3; i < 10; i++) begin tick(); chk("R9 frame completes", txd, 1); end
    tick();
    chk("R9 break at boundary", txd, 0);
    put(8'hC3);
    repeat (5) begin tick(); chk("R9 break held", txd, 0); end
    chk("R9 char not sent", hold_empty, 0);
    tx_ctl = 2'b00;
    tick();
    chk("R9 waiting char starts", txd, 0);
    chk("R9 hold freed", hold_empty, 1);
    for (int i = 1; i < 10; i++) begin tick(); chk("R9 char bit", txd, ebit(3'd5, 8'hC3, i)); end
    tick();
    tx_ctl = 2'b11;
    tick();
    chk("R9 idle break", txd, 0);
    tx_ctl = 2'b00;
    @(negedge clk);
    chk("R9 release waits for tick", txd, 0);
    tick();
    chk("R9 release marking", txd, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule